// File: doc/BRIEF.md
# Auto-Reload ETU Baud Generator

This block produces the timing strobes for a single-wire, half-duplex serial link of the smart-card kind. A free-running clock first passes through a prescaler that divides by 32, 31 or 4. The prescaled tick then advances an 8-bit up-counter. When the counter overflows, it reloads itself from a reload register and marks the end of one elementary time unit (etu). The etu therefore lasts prescale × (256 − reload) clocks.

A second strobe marks the middle of each etu, so that the receiver can sample there. A run bit starts and stops the counter, the prescaler and the line drivers together. Settings that would make an etu shorter than 8 clocks raise a sticky error flag and silence both strobes.

The same run bit, together with a transmit-direction input, drives the pin controls. While transmitting, the receiver is shut off. While receiving, the driver is released and the line is pulled high.

Top module: `etu_baud_gen`

## Requirements
- R1: After reset, etu_tick, half_tick, cfg_err, tx_en and rx_en are 0 and pullup_en is 1.
- R2: Register map: reg_sel=0 selects the control register and reg_sel=1 the reload register R. In the control register, bit 0 is run and bits 2:1 select the prescale P (00 → 32, 01 → 31, 1x → 4). The first etu_tick follows the edge that sets run by exactly P*(256−R) clocks, and later ticks repeat at that period.
- R3: half_tick pulses P*ceil((256−R)/2) clocks after each etu start. With R=0xFF it coincides with etu_tick.
- R4: Each overflow reloads the counter from the reload register. A reload write made while running takes effect at the next overflow and leaves the etu in progress unchanged.
- R5: Only a 0-to-1 change of run preloads the counter from the reload register. Writing run=1 while already running does not restart the etu.
- R6: Clearing run stops the counter at once: no strobe appears later than the cycle after the write. Clearing run also resets the prescaler phase, so a restart yields a full-length first etu.
- R7: While running with P*(256−R) < 8 (for example P=4 with R=0xFF), cfg_err rises within two cycles and stays set. Only a control write with run=0 clears it, and while it is set both strobes are suppressed.
- R8: Line controls follow run and tx_dir with one register cycle of delay. Running with tx_dir=1 gives tx_en=1, rx_en=0 and pullup_en=0. Running with tx_dir=0 gives tx_en=0, rx_en=1 and pullup_en=1. Stopped gives tx_en=0, rx_en=0 and pullup_en=1.
- R9: Each strobe is one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = reload register |
| reg_wdata | input | 8 | Write data |
| tx_dir | input | 1 | 1 = link is transmitting, 0 = receiving |
| etu_tick | output | 1 | One-clock pulse at the end of each etu |
| half_tick | output | 1 | One-clock pulse at the etu midpoint |
| cfg_err | output | 1 | Sticky illegal-configuration flag |
| tx_en | output | 1 | Drive the line from the transmitter |
| rx_en | output | 1 | Enable the receive path |
| pullup_en | output | 1 | Enable the line pull-up |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the midpoint strobe and the overflow strobe, which coincide when the etu spans a single counter step. A directed case with prescale 31 and reload 0xFF provokes this, and the bench then requires the first half_tick to arrive in the cycle of the first etu_tick, 31 clocks after the start. The second pair is a stop or reload write meeting an overflow already under way. Here the bench checks that an in-flight reload change leaves the current etu intact and sets the length of the next one, and that a restart after a stop in mid-prescale still gives a full first etu.

// File: rtl/etu_pkg.sv
package etu_pkg;

  typedef struct packed {
    logic [1:0] ps_sel;
    logic       run;
  } etu_ctrl_t;

  // prescale select: bit 1 set -> fc, else bit 0 set -> fb, else fa
  function automatic int unsigned div_factor(input logic [1:0] sel,
                                             input int unsigned fa,
                                             input int unsigned fb,
                                             input int unsigned fc);
    if (sel[1]) return fc;
    if (sel[0]) return fb;
    return fa;
  endfunction

endpackage

// File: rtl/etu_regs.sv
module etu_regs
  import etu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output etu_ctrl_t        ctrl,
  output logic [CNT_W-1:0] reload,
  output logic             load_pulse,
  output logic             err_clr
);

  logic wr_ctrl;

  assign wr_ctrl    = reg_wr & ~reg_sel;
  assign load_pulse = wr_ctrl & reg_wdata[0] & ~ctrl.run;
  assign err_clr    = wr_ctrl & ~reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      reload <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.run    <= reg_wdata[0];
        ctrl.ps_sel <= reg_wdata[2:1];
      end
      if (reg_wr && reg_sel) reload <= reg_wdata;
    end
  end

endmodule

// File: rtl/etu_prescaler.sv
module etu_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [PRE_W-1:0] div,
  output logic             pre_tick
);

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] last;

  assign last     = div - PRE_W'(1);
  assign pre_tick = run & (pcnt >= last);

  always_ff @(posedge clk) begin
    if (rst || !run || load) pcnt <= '0;
    else if (pcnt >= last)   pcnt <= '0;
    else                     pcnt <= pcnt + PRE_W'(1);
  end

endmodule

// File: rtl/etu_timer.sv
module etu_timer #(
  parameter int CNT_W        = 8,
  parameter int PRE_W        = 6,
  parameter int MIN_ETU_CLKS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic             pre_tick,
  input  logic             err_clr,
  input  logic [CNT_W-1:0] reload,
  input  logic [PRE_W-1:0] div,
  output logic             etu_tick,
  output logic             half_tick,
  output logic             cfg_err
);

  localparam int LEN_W = PRE_W + CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] half_pos;
  logic [CNT_W:0]   span;
  logic [LEN_W-1:0] etu_len;
  logic             illegal, block, wrap, etu_ev, half_ev;

  assign span     = {1'b1, {CNT_W{1'b0}}} - {1'b0, reload};
  assign etu_len  = {{(LEN_W-PRE_W){1'b0}}, div} * {{(LEN_W-CNT_W-1){1'b0}}, span};
  assign illegal  = run & (etu_len < LEN_W'(MIN_ETU_CLKS));
  assign block    = cfg_err | illegal;

  assign wrap     = &cnt;
  assign pos      = cnt - reload;
  assign half_pos = (~reload) >> 1;
  assign etu_ev   = pre_tick & wrap;
  assign half_ev  = pre_tick & (pos == half_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= reload;
    end else if (pre_tick) begin
      cnt <= wrap ? reload : cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      etu_tick  <= 1'b0;
      half_tick <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      etu_tick  <= etu_ev & ~block;
      half_tick <= half_ev & ~block;
      if (err_clr)      cfg_err <= 1'b0;
      else if (illegal) cfg_err <= 1'b1;
    end
  end

endmodule

// File: rtl/etu_line.sv
module etu_line (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tx_dir,
  output logic tx_en,
  output logic rx_en,
  output logic pullup_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en     <= 1'b0;
      rx_en     <= 1'b0;
      pullup_en <= 1'b1;
    end else begin
      tx_en     <= run & tx_dir;
      rx_en     <= run & ~tx_dir;
      pullup_en <= ~(run & tx_dir);
    end
  end

endmodule

// File: rtl/etu_baud_gen.sv
module etu_baud_gen
  import etu_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int PRE_W        = 6,
  parameter int DIV_A        = 32,
  parameter int DIV_B        = 31,
  parameter int DIV_C        = 4,
  parameter int MIN_ETU_CLKS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             tx_dir,
  output logic             etu_tick,
  output logic             half_tick,
  output logic             cfg_err,
  output logic             tx_en,
  output logic             rx_en,
  output logic             pullup_en
);

  etu_ctrl_t        ctrl;
  logic [CNT_W-1:0] reload;
  logic [PRE_W-1:0] div;
  logic             load_pulse, err_clr, pre_tick;

  assign div = PRE_W'(div_factor(ctrl.ps_sel, DIV_A, DIV_B, DIV_C));

  etu_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl(ctrl), .reload(reload),
    .load_pulse(load_pulse), .err_clr(err_clr)
  );

  etu_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(ctrl.run), .load(load_pulse),
    .div(div), .pre_tick(pre_tick)
  );

  etu_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .MIN_ETU_CLKS(MIN_ETU_CLKS)) u_tmr (
    .clk(clk), .rst(rst), .run(ctrl.run), .load(load_pulse),
    .pre_tick(pre_tick), .err_clr(err_clr), .reload(reload), .div(div),
    .etu_tick(etu_tick), .half_tick(half_tick), .cfg_err(cfg_err)
  );

  etu_line u_line (
    .clk(clk), .rst(rst), .run(ctrl.run), .tx_dir(tx_dir),
    .tx_en(tx_en), .rx_en(rx_en), .pullup_en(pullup_en)
  );

endmodule

// File: rtl/etu_baud_chk.sv
module etu_baud_chk (
  input logic clk,
  input logic rst,
  input logic stop_wr,
  input logic etu_tick,
  input logic half_tick,
  input logic cfg_err,
  input logic tx_en,
  input logic rx_en,
  input logic pullup_en
);

  // R9
  etu_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    etu_tick |=> !etu_tick);

  // R9
  half_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    half_tick |=> !half_tick);

  // R7
  err_mute_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!etu_tick && !half_tick));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !stop_wr) |=> cfg_err);

  // R6
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stop_wr |-> ##2 (!etu_tick && !half_tick));

  // R8
  tx_dir_chk: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> (!rx_en && !pullup_en));

  // R8
  rx_dir_chk: assert property (@(posedge clk) disable iff (rst)
    rx_en |-> (pullup_en && !tx_en));

endmodule

bind etu_baud_gen etu_baud_chk u_chk (
  .clk(clk), .rst(rst),
  .stop_wr(reg_wr && !reg_sel && !reg_wdata[0]),
  .etu_tick(etu_tick), .half_tick(half_tick), .cfg_err(cfg_err),
  .tx_en(tx_en), .rx_en(rx_en), .pullup_en(pullup_en)
);

// File: tb/sim_etu_baud_gen.sv
module sim_etu_baud_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       tx_dir = 1'b0;
  logic       etu_tick, half_tick, cfg_err, tx_en, rx_en, pullup_en;

  int total = 0, bad = 0, cyc = 0;
  int n_etu = 0, n_half = 0, e1 = 0, e2 = 0, h1 = 0;
  bit done = 1'b0;

  etu_baud_gen u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .tx_dir(tx_dir), .etu_tick(etu_tick),
    .half_tick(half_tick), .cfg_err(cfg_err), .tx_en(tx_en),
    .rx_en(rx_en), .pullup_en(pullup_en)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (etu_tick) begin
      if (n_etu == 0) e1 = cyc;
      else if (n_etu == 1) e2 = cyc;
      n_etu = n_etu + 1;
    end
    if (half_tick) begin
      if (n_half == 0) h1 = cyc;
      n_half = n_half + 1;
    end
  end

  function automatic int f_pre(input logic [1:0] s);
    return s[1] ? 4 : (s[0] ? 31 : 32);
  endfunction

  function automatic int f_len(input logic [1:0] s, input logic [7:0] r);
    return f_pre(s) * (256 - int'(r));
  endfunction

  function automatic int f_half(input logic [1:0] s, input logic [7:0] r);
    return f_pre(s) * ((256 - int'(r) + 1) / 2);
  endfunction

  function automatic logic [7:0] ctl(input logic [1:0] s, input logic run);
    return {5'b0, s, run};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    @(posedge clk);
    n_etu = 0; n_half = 0; e1 = 0; e2 = 0; h1 = 0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_case(input logic [1:0] s, input logic [7:0] r);
    int n, t0;
    n = f_len(s, r);
    wr(1'b1, r);
    clr();
    wr(1'b0, ctl(s, 1'b1));
    t0 = cyc;
    repeat (2 * n + 10) @(negedge clk);
    chk("R2 first etu delay", e1 - t0, n);
    chk("R2 etu period", e2 - e1, n);
    chk("R3 half delay", h1 - t0, f_half(s, r));
    chk("R7 no error on legal setting", int'(cfg_err), 0);
    wr(1'b0, ctl(s, 1'b0));
    clr();
    repeat (40) @(negedge clk);
    chk("R6 quiet after stop", n_etu + n_half, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL R2 watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0;
    int unsigned sd;
    logic [1:0] rs;
    logic [7:0] rr;
    sd = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 etu_tick", int'(etu_tick), 0);
    chk("R1 half_tick", int'(half_tick), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);
    chk("R1 tx_en", int'(tx_en), 0);
    chk("R1 rx_en", int'(rx_en), 0);
    chk("R1 pullup_en", int'(pullup_en), 1);

    // directed: smallest legal etu, coincident strobes, full-length counter
    run_case(2'b10, 8'hFE);
    run_case(2'b01, 8'hFF);
    chk("R3 half coincides with etu at R=FF", h1, e1);
    run_case(2'b00, 8'h00);
    run_case(2'b11, 8'hC3);

    // random mix
    for (int i = 0; i < 5; i++) begin
      rs = 2'($urandom % 4);
      if (rs[1]) rr = 8'($urandom % 255);
      else       rr = 8'(200 + ($urandom % 56));
      run_case(rs, rr);
    end

    // R4 reload change while running; R5 re-write of run; R8 line controls
    tx_dir = 1'b0;
    wr(1'b1, 8'hF0);
    clr();
    wr(1'b0, ctl(2'b10, 1'b1));
    t0 = cyc;
    repeat (5) @(negedge clk);
    chk("R8 rx_en while receiving", int'(rx_en), 1);
    chk("R8 pullup while receiving", int'(pullup_en), 1);
    chk("R8 tx_en while receiving", int'(tx_en), 0);
    tx_dir = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 tx_en while sending", int'(tx_en), 1);
    chk("R8 rx_en while sending", int'(rx_en), 0);
    chk("R8 pullup while sending", int'(pullup_en), 0);
    tx_dir = 1'b0;
    wr(1'b1, 8'hF8);
    wr(1'b0, ctl(2'b10, 1'b1));
    repeat (64 + 32 + 10 - (cyc - t0)) @(negedge clk);
    chk("R5 no restart on repeated run", e1 - t0, 64);
    chk("R4 new reload at next overflow", e2 - e1, 32);
    wr(1'b0, ctl(2'b10, 1'b0));
    @(negedge clk);
    @(negedge clk);
    chk("R8 tx_en stopped", int'(tx_en), 0);
    chk("R8 rx_en stopped", int'(rx_en), 0);
    chk("R8 pullup stopped", int'(pullup_en), 1);

    // R6 stop mid-prescale, restart yields full etu
    wr(1'b1, 8'hFC);
    wr(1'b0, ctl(2'b00, 1'b1));
    repeat (50) @(negedge clk);
    wr(1'b0, ctl(2'b00, 1'b0));
    clr();
    repeat (5) @(negedge clk);
    wr(1'b0, ctl(2'b00, 1'b1));
    t0 = cyc;
    repeat (140) @(negedge clk);
    chk("R6 full etu after restart", e1 - t0, 128);
    wr(1'b0, ctl(2'b00, 1'b0));

    // R7 illegal setting
    wr(1'b1, 8'hFF);
    clr();
    wr(1'b0, ctl(2'b10, 1'b1));
    @(negedge clk);
    chk("R7 error raised", int'(cfg_err), 1);
    repeat (60) @(negedge clk);
    wr(1'b1, 8'hF0);
    repeat (100) @(negedge clk);
    chk("R7 error stays set", int'(cfg_err), 1);
    chk("R7 strobes suppressed", n_etu + n_half, 0);
    wr(1'b0, ctl(2'b10, 1'b0));
    chk("R7 error cleared by stop write", int'(cfg_err), 0);
    run_case(2'b10, 8'hF0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule